// File: doc/BRIEF.md
# Byte-Wide Cartridge Bus Host Controller

This block is the host side of a synchronous, half-duplex cartridge bus. The bus has eight data lines and a transaction is framed by an active-low select. A local requester hands over a 16-byte command, the number of response bytes it expects and a busy-wait limit, then pulses a start strobe. The controller lowers select, enables the bus clock and drives the command followed by its CRC-32. It then releases the lines for two turnaround cycles and reads back a status byte. If the command was accepted, it waits for the device to finish being busy, which the device shows on data line 0. Once the two-cycle ready marker appears, it streams the response bytes to the local side and checks the CRC-32 that follows them.

The bus pads are modelled as separate output, output-enable and input vectors. The bus clock is the block clock qualified by `bus_clk_en`. Every byte the host drives is valid for a whole cycle before the device samples it on the next rising edge. Every byte the device returns is sampled by the host on a rising edge. Completion is one cycle with select high and a pulse on `done`. In that cycle `done_status` reports one of four outcomes: 0 ok, 1 command rejected, 2 response CRC mismatch, 3 busy timeout.

The controller is a single state machine with these states:
- IDLE
- SEND_CMD (16 cycles)
- SEND_CRC (4 cycles)
- TURN (2 cycles)
- STATUS (1 cycle)
- BUSY_WAIT
- READY_2ND
- RECV_DATA (length cycles)
- RECV_CRC (4 cycles)
- FINISH (1 cycle)

Its transitions are:
- IDLE goes to SEND_CMD on a start.
- SEND_CMD goes to SEND_CRC after byte 15.
- SEND_CRC goes to TURN after CRC byte 3.
- TURN goes to STATUS after two cycles.
- STATUS goes to BUSY_WAIT on 0x00, or to FINISH on any other value.
- BUSY_WAIT goes to READY_2ND when line 0 reads high.
- READY_2ND goes to RECV_DATA on a second high, or to RECV_CRC on a second high when the length is zero.
- READY_2ND goes back to BUSY_WAIT when line 0 reads low.
- BUSY_WAIT and READY_2ND go to FINISH when the wait limit is used up.
- RECV_DATA goes to RECV_CRC after the last byte.
- RECV_CRC goes to FINISH after CRC byte 3.
- FINISH goes to IDLE.

Top module: `cbus_host`

## Requirements
- R1: After reset the block is idle: `bus_cs_n`=1, `bus_clk_en`=0, `bus_oe`=0, `rsp_valid`=0, `done`=0.
- R2: A `req_start` seen in IDLE makes the next cycle the first of 16 command cycles. In command cycle i, `bus_cs_n`=0, `bus_clk_en`=1 and `bus_oe`=1, and `bus_dout` carries `req_cmd[8i+7:8i]`.
- R3: The 4 cycles right after the command drive the CRC-32 of the 16 command bytes with `bus_oe`=1, least-significant byte first. The CRC uses the reflected polynomial 0xEDB88320, a start value of 0xFFFFFFFF and a final inversion.
- R4: The next 2 cycles have `bus_oe`=0 and ignore the bus. In the cycle after them the input is sampled as status: 0x00 accepts, and any other value ends the transaction with status 1.
- R5: After acceptance, only bit 0 of `bus_din` is examined in each wait cycle. Two consecutive high samples form the ready marker, and the first response byte is sampled in the cycle after the second high.
- R6: If the ready marker is not complete within `busy_timeout` wait samples (0 acts as 1), the transaction ends with status 3.
- R7: Exactly `req_rsp_len` response bytes are captured. Each one appears on `rsp_data` with `rsp_valid`=1 in the cycle after it is sampled, in bus order. A length of 0 yields no `rsp_valid`.
- R8: The 4 bytes after the response (least-significant first) are compared with the CRC-32 of the response bytes. A match gives status 0 and a mismatch gives status 2.
- R9: Every transaction ends with exactly one cycle in which `bus_cs_n`=1, `bus_clk_en`=0, `done`=1 and `done_status` holds the outcome. The block is idle in the cycle after that.
- R10: `req_start` outside IDLE is ignored. The command, length and wait limit are captured at start, so later changes to those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the bus clock when enabled |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe, taken only in IDLE |
| req_cmd | input | 128 | Command, byte i in bits 8i+7:8i, byte 0 sent first |
| req_rsp_len | input | LEN_W | Expected response byte count |
| busy_timeout | input | TO_W | Maximum number of busy-wait samples |
| bus_cs_n | output | 1 | Active-low transaction select |
| bus_clk_en | output | 1 | Bus clock enable, high while selected |
| bus_dout | output | 8 | Data driven toward the device |
| bus_oe | output | 1 | Drive enable for the data lines |
| bus_din | input | 8 | Data sampled from the device |
| rsp_valid | output | 1 | Response byte strobe |
| rsp_data | output | 8 | Response byte |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | Outcome: 0 ok, 1 rejected, 2 response CRC bad, 3 timeout |

## Verification
An off-by-one in the byte counter shows at once as a wrong byte on `bus_dout`, or as `bus_oe` held one cycle too long or dropped one cycle too early. A corrupted CRC register shows on the first CRC byte. A wrong turnaround or ready-detect state moves the first `rsp_valid` by a cycle, or ends the transaction with the wrong `done_status`. The reference model compares every port in every cycle, so a fault is reported in the cycle where it first appears, not at the end of the transaction.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

    parameter int CMD_BYTES   = 16;
    parameter int CRC_BYTES   = 4;
    parameter int TURN_CYCLES = 2;
    parameter logic [31:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEND_CMD,
        ST_SEND_CRC,
        ST_TURN,
        ST_STATUS,
        ST_BUSY_WAIT,
        ST_READY_2ND,
        ST_RECV_DATA,
        ST_RECV_CRC,
        ST_FINISH
    } state_t;

    typedef enum logic [1:0] {
        DS_OK      = 2'd0,
        DS_CMD_REJ = 2'd1,
        DS_RSP_CRC = 2'd2,
        DS_TIMEOUT = 2'd3
    } done_code_t;

    // One byte of reflected CRC-32, data bit 0 first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/cbus_crc32.sv
module cbus_crc32
    import cbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc_final
);

    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= 32'hFFFF_FFFF;
        else if (clr) crc_q <= 32'hFFFF_FFFF;
        else if (en)  crc_q <= crc32_step(crc_q, data);
    end

    assign crc_final = ~crc_q;

endmodule

// File: rtl/cbus_wait_timer.sv
module cbus_wait_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [TO_W-1:0] limit,
    output logic            expire
);

    logic [TO_W-1:0] cnt_q;
    logic [TO_W:0]   cnt_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (en)  cnt_q <= cnt_q + 1'b1;
    end

    // This sample is the last one allowed when it brings the count to the limit.
    assign cnt_next = {1'b0, cnt_q} + {{TO_W{1'b0}}, 1'b1};
    assign expire   = (cnt_next >= {1'b0, limit});

endmodule

// File: rtl/cbus_host.sv
module cbus_host
    import cbus_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic [127:0]     req_cmd,
    input  logic [LEN_W-1:0] req_rsp_len,
    input  logic [TO_W-1:0]  busy_timeout,
    output logic             bus_cs_n,
    output logic             bus_clk_en,
    output logic [7:0]       bus_dout,
    output logic             bus_oe,
    input  logic [7:0]       bus_din,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             done,
    output logic [1:0]       done_status
);

    localparam int CNT_W = (LEN_W > 5) ? LEN_W : 5;
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BYTES - 1);
    localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_BYTES - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYCLES - 1);

    state_t            state_q, state_d;
    logic [CNT_W-1:0]  idx_q;
    logic [127:0]      cmd_q;
    logic [LEN_W-1:0]  len_q;
    logic [TO_W-1:0]   limit_q;
    done_code_t        status_q, fin_status_d;
    logic              fin_load;
    logic [23:0]       rx_word_q;
    logic              rsp_valid_q;
    logic [7:0]        rsp_data_q;

    logic              start_acc;
    logic [7:0]        cmd_byte;
    logic [31:0]       tx_crc, rx_crc;
    logic              in_wait;
    logic              wait_expire;
    logic [CNT_W-1:0]  len_last;

    assign start_acc = (state_q == ST_IDLE) && req_start;
    assign cmd_byte  = cmd_q[{idx_q[3:0], 3'b000} +: 8];
    assign in_wait   = (state_q == ST_BUSY_WAIT) || (state_q == ST_READY_2ND);
    assign len_last  = CNT_W'(len_q) - CNT_W'(1);

    cbus_crc32 tx_crc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_acc),
        .en        (state_q == ST_SEND_CMD),
        .data      (cmd_byte),
        .crc_final (tx_crc)
    );

    cbus_crc32 rx_crc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_acc),
        .en        (state_q == ST_RECV_DATA),
        .data      (bus_din),
        .crc_final (rx_crc)
    );

    cbus_wait_timer #(.TO_W(TO_W)) wait_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!in_wait),
        .en     (in_wait),
        .limit  (limit_q),
        .expire (wait_expire)
    );

    // Next state and completion code.
    always_comb begin
        state_d      = state_q;
        fin_load     = 1'b0;
        fin_status_d = DS_OK;
        unique case (state_q)
            ST_IDLE: begin
                if (req_start) state_d = ST_SEND_CMD;
            end
            ST_SEND_CMD: begin
                if (idx_q == CMD_LAST) state_d = ST_SEND_CRC;
            end
            ST_SEND_CRC: begin
                if (idx_q == CRC_LAST) state_d = ST_TURN;
            end
            ST_TURN: begin
                if (idx_q == TURN_LAST) state_d = ST_STATUS;
            end
            ST_STATUS: begin
                if (bus_din == 8'h00) begin
                    state_d = ST_BUSY_WAIT;
                end else begin
                    state_d      = ST_FINISH;
                    fin_load     = 1'b1;
                    fin_status_d = DS_CMD_REJ;
                end
            end
            ST_BUSY_WAIT: begin
                if (wait_expire) begin
                    state_d      = ST_FINISH;
                    fin_load     = 1'b1;
                    fin_status_d = DS_TIMEOUT;
                end else if (bus_din[0]) begin
                    state_d = ST_READY_2ND;
                end
            end
            ST_READY_2ND: begin
                if (bus_din[0]) begin
                    state_d = (len_q == '0) ? ST_RECV_CRC : ST_RECV_DATA;
                end else if (wait_expire) begin
                    state_d      = ST_FINISH;
                    fin_load     = 1'b1;
                    fin_status_d = DS_TIMEOUT;
                end else begin
                    state_d = ST_BUSY_WAIT;
                end
            end
            ST_RECV_DATA: begin
                if (idx_q == len_last) state_d = ST_RECV_CRC;
            end
            ST_RECV_CRC: begin
                if (idx_q == CRC_LAST) begin
                    state_d      = ST_FINISH;
                    fin_load     = 1'b1;
                    fin_status_d = ({bus_din, rx_word_q} == rx_crc) ? DS_OK : DS_RSP_CRC;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and per-state byte counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) idx_q <= '0;
            else                    idx_q <= idx_q + 1'b1;
        end
    end

    // Request capture, response CRC word and response stream.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            len_q       <= '0;
            limit_q     <= '0;
            status_q    <= DS_OK;
            rx_word_q   <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            if (start_acc) begin
                cmd_q   <= req_cmd;
                len_q   <= req_rsp_len;
                limit_q <= busy_timeout;
            end
            if (fin_load) status_q <= fin_status_d;
            if (state_q == ST_RECV_CRC) rx_word_q <= {bus_din, rx_word_q[23:8]};
            rsp_valid_q <= (state_q == ST_RECV_DATA);
            if (state_q == ST_RECV_DATA) rsp_data_q <= bus_din;
        end
    end

    // Outputs.
    always_comb begin
        bus_cs_n    = 1'b1;
        bus_oe      = 1'b0;
        bus_dout    = 8'h00;
        done        = 1'b0;
        done_status = 2'd0;
        unique case (state_q)
            ST_IDLE: begin
                bus_cs_n = 1'b1;
            end
            ST_SEND_CMD: begin
                bus_cs_n = 1'b0;
                bus_oe   = 1'b1;
                bus_dout = cmd_byte;
            end
            ST_SEND_CRC: begin
                bus_cs_n = 1'b0;
                bus_oe   = 1'b1;
                bus_dout = tx_crc[{idx_q[1:0], 3'b000} +: 8];
            end
            ST_TURN, ST_STATUS, ST_BUSY_WAIT, ST_READY_2ND,
            ST_RECV_DATA, ST_RECV_CRC: begin
                bus_cs_n = 1'b0;
            end
            ST_FINISH: begin
                bus_cs_n    = 1'b1;
                done        = 1'b1;
                done_status = status_q;
            end
            default: begin
                bus_cs_n = 1'b1;
            end
        endcase
        bus_clk_en = !bus_cs_n;
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/cbus_host_chk.sv
module cbus_host_chk (
    input logic clk,
    input logic rst_n,
    input logic req_start,
    input logic bus_cs_n,
    input logic bus_clk_en,
    input logic bus_oe,
    input logic rsp_valid,
    input logic done
);

    // R2
    oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!bus_cs_n && bus_clk_en));

    // R10
    select_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> $past(req_start));

    // R4
    turnaround_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |=> (!bus_oe && !bus_cs_n));

    // R7
    rsp_while_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !bus_oe);

    // R9
    done_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_cs_n && !bus_clk_en && !bus_oe));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && bus_cs_n));

endmodule

bind cbus_host cbus_host_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .bus_cs_n   (bus_cs_n),
    .bus_clk_en (bus_clk_en),
    .bus_oe     (bus_oe),
    .rsp_valid  (rsp_valid),
    .done       (done)
);

// File: tb/cbus_host_tb.sv
module cbus_host_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 10;
    localparam int TO_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_start = 1'b0;
    logic [127:0]     req_cmd = '0;
    logic [LEN_W-1:0] req_rsp_len = '0;
    logic [TO_W-1:0]  busy_timeout = '0;
    logic             bus_cs_n, bus_clk_en, bus_oe;
    logic [7:0]       bus_dout;
    logic [7:0]       bus_din = 8'hFF;
    logic             rsp_valid;
    logic [7:0]       rsp_data;
    logic             done;
    logic [1:0]       done_status;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbus_host #(.LEN_W(LEN_W), .TO_W(TO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
        .req_rsp_len(req_rsp_len), .busy_timeout(busy_timeout),
        .bus_cs_n(bus_cs_n), .bus_clk_en(bus_clk_en), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_din(bus_din), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .done(done), .done_status(done_status)
    );

    function automatic logic [31:0] ref_crc(input byte unsigned b[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (b[i]) begin
            c = c ^ {24'h0, b[i]};
            repeat (8) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare all ports against the expected values for this cycle.
    task automatic cmp(input string req, input bit e_cs_n, input bit e_oe,
                       input logic [7:0] e_dout, input bit e_rv, input logic [7:0] e_rd,
                       input bit e_done, input logic [1:0] e_st);
        logic [31:0] a, e;
        a = {8'h0, bus_cs_n, bus_clk_en, bus_oe, rsp_valid, done,
             (e_oe ? bus_dout : 8'h00), (e_rv ? rsp_data : 8'h00),
             (e_done ? done_status : 2'd0), 1'b0};
        e = {8'h0, e_cs_n, !e_cs_n, e_oe, e_rv, e_done,
             (e_oe ? e_dout : 8'h00), (e_rv ? e_rd : 8'h00),
             (e_done ? e_st : 2'd0), 1'b0};
        chk(a == e, req, "ports{cs,ce,oe,rv,done,dout,rdata,st}", a, e);
    endtask

    task automatic run_txn(input logic [127:0] cmd, input int len, input int tmo,
                           input int nbusy, input logic [7:0] stat, input bit bad_crc,
                           input bit poke);
        byte unsigned cq[$];
        byte unsigned dq[$];
        logic [31:0] ccrc, dcrc;
        int teff, d0, fin;
        bit accepted, ready_ok;
        logic [1:0] st;
        string req;
        for (int i = 0; i < 16; i++) cq.push_back(cmd[8*i +: 8]);
        for (int j = 0; j < len; j++) dq.push_back(8'((j * 7 + 3) ^ cmd[7:0]));
        ccrc = ref_crc(cq);
        dcrc = ref_crc(dq);
        if (bad_crc) dcrc = dcrc ^ 32'h0001_0000;
        teff = (tmo < 1) ? 1 : tmo;
        accepted = (stat == 8'h00);
        ready_ok = (nbusy + 2) <= teff;
        d0 = 25 + nbusy;
        if (!accepted)     begin fin = 23;            st = 2'd1; end
        else if (ready_ok) begin fin = d0 + len + 4;  st = bad_crc ? 2'd2 : 2'd0; end
        else               begin fin = 23 + teff;     st = 2'd3; end

        @(negedge clk);
        req_cmd = cmd; req_rsp_len = LEN_W'(len); busy_timeout = TO_W'(tmo);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        for (int t = 0; t <= fin + 1; t++) begin
            bit e_oe, e_rv;
            logic [7:0] e_dout, e_rd;
            e_oe = (t < 20);
            e_dout = (t < 16) ? cq[t] : (t < 20) ? ccrc[8*(t-16) +: 8] : 8'h00;
            e_rv = accepted && ready_ok && (t >= d0 + 1) && (t <= d0 + len);
            e_rd = e_rv ? dq[t-d0-1] : 8'h00;
            if (t > fin)       req = "R9";
            else if (t == fin) req = (st == 2'd1) ? "R4" : (st == 2'd3) ? "R6" : "R8";
            else if (t < 16)   req = "R2";
            else if (t < 20)   req = "R3";
            else if (t <= 22)  req = "R4";
            else if (t < d0)   req = "R5";
            else               req = "R7";
            cmp(req, (t >= fin), e_oe, e_dout, e_rv, e_rd, (t == fin), st);
            if (poke && t == 5) begin
                // R10: start and new inputs mid-transaction must be ignored
                req_start = 1'b1; req_cmd = ~cmd; req_rsp_len = LEN_W'(len + 3);
                busy_timeout = 16'd1;
            end else if (poke && t == fin) begin
                req_start = 1'b1;  // R10: ignored in the completion cycle
            end else begin
                req_start = 1'b0;
            end
            // device response for the next rising edge
            if (t == 22)                        bus_din = stat;
            else if (t >= 23 && t < d0)         bus_din = ((t - 22) <= nbusy) ? 8'hFE : 8'h01;
            else if (t >= d0 && t < d0 + len)   bus_din = dq[t-d0];
            else if (t >= d0 + len && t < d0 + len + 4) bus_din = dcrc[8*(t-d0-len) +: 8];
            else                                bus_din = 8'hFF;
            if (!accepted || !ready_ok) begin
                if (t >= 23 && t < d0 && accepted) bus_din = ((t - 22) <= nbusy) ? 8'hFE : 8'h01;
                if (t >= d0) bus_din = 8'hFF;
            end
            @(negedge clk);
        end
        req_start = 1'b0;
        bus_din = 8'hFF;
        // R10 / R9: still idle after the ignored strobe
        cmp("R10", 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cmp("R1", 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0);

        // R7 R8: sector-style read, 512 bytes
        run_txn(128'h0000_0000_0000_0001_0000_0000_0000_005B, 512, 100, 3, 8'h00, 1'b0, 1'b0);
        // R5 R6: ready on exactly the last allowed sample
        run_txn(128'h56, 4, 2, 0, 8'h00, 1'b0, 1'b0);
        // R7: no response data, limit met exactly
        run_txn(128'hA5_1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A, 0, 7, 5, 8'h00, 1'b0, 1'b0);
        // R6: one sample short of the marker
        run_txn(128'h28, 4, 6, 5, 8'h00, 1'b0, 1'b0);
        // R6: limit zero behaves as one
        run_txn(128'hE2, 4, 0, 0, 8'h00, 1'b0, 1'b0);
        // R4: rejected command, two status codes
        run_txn(128'h5B, 4, 50, 1, 8'h01, 1'b0, 1'b0);
        run_txn(128'h5B, 4, 50, 1, 8'h80, 1'b0, 1'b0);
        // R8: response CRC mismatch
        run_txn(128'hE0_FFEE_DDCC, 32, 50, 2, 8'h00, 1'b1, 1'b0);
        // R10: strobes while busy are ignored
        run_txn(128'hC3_0102_0304_0506_0708, 8, 20, 4, 8'h00, 1'b0, 1'b1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule